// File: doc/BRIEF.md
# Serial Control Register Port

This block is the register-access front end of a frequency-synthesizer controller. An external master drives a framed serial link made of an active-low select, a serial clock, a data input and a data output. The block oversamples these pins with its own system clock. Each framed access starts with one instruction byte. A single data byte follows it, and that byte is either written into the control word or read back from it. The 32-bit control word sits at four consecutive byte addresses. Its fields go straight to the synthesizer datapath as plain level outputs. The one exception is an accumulator-clear strobe that lasts one cycle.

The link has no valid/ready handshake, so there is no back-pressure. The master paces every bit with the serial clock, and the port must keep up with it. It does so when each serial clock half period spans at least six system clock cycles. The bit order can be changed at run time by a bit in the control word. That bit also governs the instruction byte. One bit in the word is a trap: writing it halts the port until a master reset.

Top module: `sctl_serial_port`

## Requirements
- R1: After rst_n is released, the control word is 0x0060_0000. Address 0x1E reads 0x60 and addresses 0x1D, 0x1F and 0x20 read 0x00. The port starts MSB-first, pll_range and pll_bypass are 1, and halted is 0.
- R2: Bit 7 of the instruction byte is the read flag (1 = read, 0 = write), and bits 6:0 are the address. The instruction byte is followed by exactly one data byte. A write takes effect on the rising serial clock edge that carries the eighth data bit.
- R3: Each address maps to one byte of the word: 0x1D holds bits 31:24, 0x1E holds 23:16, 0x1F holds 15:8 and 0x20 holds 7:0. Any other address reads 0x00, and writes to it change nothing.
- R4: Word bits 31:29 and 23 are never stored and always read 0.
- R5: When word bit 1 (address 0x20, bit 1) is 1, every byte travels LSB-first. This covers the instruction byte, incoming data and outgoing data. When the bit is 0, every byte travels MSB-first.
- R6: A change of the order bit applies from the next framed access onward. The access that writes the bit completes in the order it started with.
- R7: sdi is sampled on rising serial clock edges. sdo changes only on falling edges. The first read bit appears after the falling edge that follows the eighth instruction bit. sdo is 0 whenever cs_n is high.
- R8: Raising cs_n before the data byte is complete aborts the access. Nothing is written, and the next access starts again from its instruction byte.
- R9: Writing 1 to word bit 15 (address 0x1F, bit 7) produces a one-system-cycle pulse on acc1_clr. That bit always reads back 0.
- R10: Writing 1 to word bit 27 (address 0x1D, bit 3) sets halted, and the rest of that write is discarded. While halted, writes are ignored, sdo stays 0 and all exported fields stay frozen. Only rst_n clears the halted state.
- R11: pll_mult_ok is 1 exactly when pll_bypass is 0 and the multiplier field (bits 20:16) lies between 4 and 20 inclusive.
- R12: The exported fields follow the word as follows. cmp_pd is bit 28, qdac_pd is 26, dac_pd is 25, dig_pd is 24, pll_range is 22, pll_bypass is 21 and pll_mult is 20:16. acc_clr_hold is 14, triangle is 13, q_src is 12, op_mode is 11:9 and lsb_first is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial read data |
| cmp_pd | output | 1 | Comparator power-down flag |
| qdac_pd | output | 1 | Q converter power-down flag |
| dac_pd | output | 1 | Both converters power-down flag |
| dig_pd | output | 1 | Digital section power-down flag |
| pll_range | output | 1 | High VCO gain select |
| pll_bypass | output | 1 | Reference drives system clock directly |
| pll_mult | output | 5 | Clock multiplier field |
| pll_mult_ok | output | 1 | Multiplier is in use and legal |
| acc1_clr | output | 1 | One-cycle accumulator clear strobe |
| acc_clr_hold | output | 1 | Hold both accumulators at zero |
| triangle | output | 1 | Up/down sweep enable |
| q_src | output | 1 | Q path takes data from its register |
| op_mode | output | 3 | Operating mode code |
| lsb_first | output | 1 | Configured bit order (1 = LSB-first) |
| halted | output | 1 | Lockout active |

## Verification
Bytes whose bit patterns are not symmetric are written and read back in both bit orders. A port that reverses the order in one direction only, or mishandles the instruction byte, therefore returns the wrong value. Write values with reserved bits set show the masking. The pll_mult_ok checks use multipliers just inside and just outside the legal range, with the bypass bit both on and off. Further patterns cover frames cut short in the instruction byte and in the data byte, a write to an unmapped address, the one-shot strobe, and the lockout followed by a master reset. Together they distinguish an aborted frame from a committed one, a pulse from a level, and a frozen port from one that is still live.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int BYTE_W  = 8;
  localparam int N_LANES = 4;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  // bits that are held in storage; reserved, one-shot and trap bits excluded
  localparam logic [31:0] KEEP_MASK = 32'h177F_7FFF;

  function automatic logic mult_legal(input logic [4:0] m, input int lo, input int hi);
    return (int'(m) >= lo) && (int'(m) <= hi);
  endfunction

endpackage

// File: rtl/sctl_sync_bit.sv
module sctl_sync_bit #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= INIT;
        else        pipe <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= {STAGES{INIT}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sctl_front.sv
module sctl_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_act,
  output logic rise,
  output logic fall,
  output logic sdi_s
);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] INITS = 3'b010;

  logic [NPINS-1:0] raw, synced;
  logic sclk_d;

  assign raw = {sdi, cs_n, sclk};

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      sctl_sync_bit #(.STAGES(STAGES), .INIT(INITS[i])) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(synced[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= synced[0];

  assign cs_act = ~synced[1];
  assign sdi_s  = synced[2];
  assign rise   = cs_act &  synced[0] & ~sclk_d;
  assign fall   = cs_act & ~synced[0] &  sclk_d;

  a_r7_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift
  import sctl_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi_s,
  input  logic              cfg_lsb,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo_q
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt, tx_idx;
  logic [BYTE_W-1:0] sh, sh_next;
  logic              is_read, order_q;
  logic [ADDR_W-1:0] addr_q;

  assign sh_next  = order_q ? {sdi_s, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], sdi_s};
  assign acc_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      tx_idx  <= '0;
      sh      <= '0;
      is_read <= 1'b0;
      addr_q  <= '0;
      order_q <= 1'b0;
      sdo_q   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_INSTR;
        bit_cnt <= '0;
        tx_idx  <= '0;
        sdo_q   <= 1'b0;
        order_q <= cfg_lsb;
      end else begin
        if (rise && phase != PH_DONE) begin
          sh      <= sh_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST) begin
            if (phase == PH_INSTR) begin
              is_read <= sh_next[BYTE_W-1];
              addr_q  <= sh_next[ADDR_W-1:0];
              phase   <= PH_DATA;
            end else begin
              phase <= PH_DONE;
              if (!is_read) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= sh_next;
              end
            end
          end
        end
        if (fall && phase == PH_DATA && is_read) begin
          sdo_q  <= order_q ? rd_byte[tx_idx] : rd_byte[LAST - tx_idx];
          tx_idx <= tx_idx + 1'b1;
        end
      end
    end
  end

  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !fall) |=> $stable(sdo_q));
  a_r7_sdo_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_q);
  a_r6_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |=> $stable(order_q));
  a_r2_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rise && cs_act));
  a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act) |=> !wr_en);
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          BASE       = 'h1D,
  parameter logic [31:0] RESET_WORD = 32'h0060_0000,
  parameter int          HALT_BIT   = 27,
  parameter int          PULSE_BIT  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [31:0]       word,
  output logic              acc1_clr,
  output logic              halted
);
  localparam int HALT_LANE  = N_LANES - 1 - HALT_BIT / BYTE_W;
  localparam int HALT_POS   = HALT_BIT % BYTE_W;
  localparam int PULSE_LANE = N_LANES - 1 - PULSE_BIT / BYTE_W;
  localparam int PULSE_POS  = PULSE_BIT % BYTE_W;

  logic [N_LANES-1:0] wr_hit, rd_hit;
  logic [31:0]        merged;
  logic [BYTE_W-1:0]  lane_rd [N_LANES];
  logic               live, halt_req, pulse_req;

  generate
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      localparam int LO = (N_LANES - 1 - k) * BYTE_W;
      assign wr_hit[k]  = (wr_addr == ADDR_W'(BASE + k));
      assign rd_hit[k]  = (rd_addr == ADDR_W'(BASE + k));
      assign merged[LO +: BYTE_W] = wr_hit[k] ? wr_data : word[LO +: BYTE_W];
      assign lane_rd[k] = rd_hit[k] ? word[LO +: BYTE_W] : '0;
    end
  endgenerate

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < N_LANES; k++) rd_byte = rd_byte | lane_rd[k];
  end

  assign live      = wr_en && !halted;
  assign halt_req  = live && wr_hit[HALT_LANE]  && wr_data[HALT_POS];
  assign pulse_req = live && wr_hit[PULSE_LANE] && wr_data[PULSE_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= RESET_WORD & KEEP_MASK;
      halted   <= 1'b0;
      acc1_clr <= 1'b0;
    end else begin
      acc1_clr <= pulse_req;
      if (halt_req)
        halted <= 1'b1;
      else if (live && (|wr_hit))
        word <= merged & KEEP_MASK;
    end
  end

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(word));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc1_clr |=> !acc1_clr);
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc1_clr |-> $past(wr_en && !halted));
  a_r4_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit[0] |-> (rd_byte[7:5] == 3'b000));
  a_r3_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rd_hit) |-> (rd_byte == '0));
endmodule

// File: rtl/sctl_serial_port.sv
module sctl_serial_port
  import sctl_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 7,
  parameter int          BASE        = 'h1D,
  parameter logic [31:0] RESET_WORD  = 32'h0060_0000,
  parameter int          MULT_MIN    = 4,
  parameter int          MULT_MAX    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       cmp_pd,
  output logic       qdac_pd,
  output logic       dac_pd,
  output logic       dig_pd,
  output logic       pll_range,
  output logic       pll_bypass,
  output logic [4:0] pll_mult,
  output logic       pll_mult_ok,
  output logic       acc1_clr,
  output logic       acc_clr_hold,
  output logic       triangle,
  output logic       q_src,
  output logic [2:0] op_mode,
  output logic       lsb_first,
  output logic       halted
);
  logic              cs_act, rise, fall, sdi_s, sdo_q, wr_en;
  logic [ADDR_W-1:0] acc_addr, wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [31:0]       word;

  sctl_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_act(cs_act), .rise(rise), .fall(fall), .sdi_s(sdi_s)
  );

  sctl_shift #(.ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise), .fall(fall),
    .sdi_s(sdi_s), .cfg_lsb(word[1]), .rd_byte(rd_byte),
    .acc_addr(acc_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdo_q(sdo_q)
  );

  sctl_regs #(.ADDR_W(ADDR_W), .BASE(BASE), .RESET_WORD(RESET_WORD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(acc_addr), .rd_byte(rd_byte),
    .word(word), .acc1_clr(acc1_clr), .halted(halted)
  );

  assign sdo          = sdo_q & ~halted;
  assign cmp_pd       = word[28];
  assign qdac_pd      = word[26];
  assign dac_pd       = word[25];
  assign dig_pd       = word[24];
  assign pll_range    = word[22];
  assign pll_bypass   = word[21];
  assign pll_mult     = word[20:16];
  assign pll_mult_ok  = !word[21] && mult_legal(word[20:16], MULT_MIN, MULT_MAX);
  assign acc_clr_hold = word[14];
  assign triangle     = word[13];
  assign q_src        = word[12];
  assign op_mode      = word[11:9];
  assign lsb_first    = word[1];

  a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !sdo);
  a_r11_bypass_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass |-> !pll_mult_ok);
endmodule

// File: tb/sctl_serial_port_test.sv
`timescale 1ns/1ps
module sctl_serial_port_test;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, cmp_pd, qdac_pd, dac_pd, dig_pd, pll_range, pll_bypass;
  logic [4:0] pll_mult;
  logic pll_mult_ok, acc1_clr, acc_clr_hold, triangle, q_src, lsb_first, halted;
  logic [2:0] op_mode;

  int checks = 0, errors = 0, pulses = 0;
  bit lsb_mode = 0, done = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sctl_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .cmp_pd(cmp_pd), .qdac_pd(qdac_pd), .dac_pd(dac_pd), .dig_pd(dig_pd),
    .pll_range(pll_range), .pll_bypass(pll_bypass), .pll_mult(pll_mult),
    .pll_mult_ok(pll_mult_ok), .acc1_clr(acc1_clr), .acc_clr_hold(acc_clr_hold),
    .triangle(triangle), .q_src(q_src), .op_mode(op_mode),
    .lsb_first(lsb_first), .halted(halted)
  );

  always @(posedge clk) if (rst_n && acc1_clr) pulses++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  // nbits: total bits shifted (16 for a full frame)
  task automatic frame(logic [7:0] ins, logic [7:0] dat, int nbits, output logic [7:0] rx);
    rx = '0;
    cs_n = 1'b0;
    half_wait();
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) sdi = lsb_mode ? ins[i] : ins[7-i];
      else       sdi = lsb_mode ? dat[i-8] : dat[15-i];
      half_wait();
      if (i >= 8) begin
        if (lsb_mode) rx[i-8] = sdo; else rx[15-i] = sdo;
      end
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
    half_wait();
    cs_n = 1'b1;
    repeat (4) half_wait();
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    logic [7:0] rx;
    frame({1'b0, a}, d, 16, rx);
  endtask

  task automatic rd(logic [6:0] a, logic [7:0] exp, string req);
    logic [7:0] rx;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    frame({1'b1, a}, 8'h00, 16, rx);
    got_q.push_back(rx);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    lsb_mode = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    logic [7:0] rx;
    do_reset();
    check("R1 halted", halted, 0);
    check("R1 pll_range", pll_range, 1);
    check("R1 pll_bypass", pll_bypass, 1);
    check("R1 lsb_first", lsb_first, 0);
    check("R7 sdo idle", sdo, 0);
    rd(7'h1E, 8'h60, "R1 addr1E");
    rd(7'h1D, 8'h00, "R1 addr1D");
    rd(7'h20, 8'h00, "R1 addr20");

    wr(7'h1D, 8'hF7);
    check("R12 cmp_pd", cmp_pd, 1);
    check("R12 pd group", {qdac_pd, dac_pd, dig_pd}, 3'b111);
    rd(7'h1D, 8'h17, "R4 bits31_29");

    wr(7'h1E, 8'h94);
    rd(7'h1E, 8'h14, "R4 bit23");
    check("R11 mult20", {pll_range, pll_bypass, pll_mult, pll_mult_ok}, {2'b00, 5'd20, 1'b1});
    wr(7'h1E, 8'h15);
    check("R11 mult21", pll_mult_ok, 0);
    wr(7'h1E, 8'h03);
    check("R11 mult3", pll_mult_ok, 0);
    wr(7'h1E, 8'h04);
    check("R11 mult4", pll_mult_ok, 1);
    wr(7'h1E, 8'h24);
    check("R11 bypass", {pll_bypass, pll_mult_ok}, 2'b10);

    wr(7'h1F, 8'h3B);
    check("R12 fields", {triangle, q_src, op_mode}, {2'b11, 3'd5});
    rd(7'h1F, 8'h3B, "R2 readback");
    rd(7'h1E, 8'h24, "R7 first bit timing");

    wr(7'h05, 8'hAA);
    rd(7'h05, 8'h00, "R3 unmapped");
    rd(7'h1F, 8'h3B, "R3 untouched");

    p0 = pulses;
    wr(7'h1F, 8'hC0);
    check("R9 one pulse", pulses - p0, 1);
    check("R12 hold", {acc_clr_hold, triangle, op_mode}, {2'b10, 3'd0});
    rd(7'h1F, 8'h40, "R9 reads zero");

    wr(7'h20, 8'h02);
    lsb_mode = 1;
    check("R5 lsb_first", lsb_first, 1);
    rd(7'h20, 8'h02, "R5 lsb read");
    wr(7'h1F, 8'h06);
    rd(7'h1F, 8'h06, "R5 lsb roundtrip");
    check("R5 op_mode", op_mode, 3);

    wr(7'h20, 8'h80);
    lsb_mode = 0;
    check("R6 order cleared", lsb_first, 0);
    rd(7'h20, 8'h80, "R6 msb after switch");

    frame({1'b0, 7'h1F}, 8'hFF, 13, rx);
    rd(7'h1F, 8'h06, "R8 data abort");
    frame({1'b0, 7'h1F}, 8'hFF, 3, rx);
    rd(7'h1F, 8'h06, "R8 instr abort");

    wr(7'h1D, 8'h08);
    check("R10 halted", halted, 1);
    check("R10 rest kept", cmp_pd, 1);
    rd(7'h1E, 8'h00, "R10 sdo quiet");
    wr(7'h1F, 8'h02);
    check("R10 frozen", op_mode, 3);
    do_reset();
    check("R10 reset clears", halted, 0);
    rd(7'h1E, 8'h60, "R10 defaults back");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule